// File: doc/BRIEF.md
# Coincidence-Gated Frequency Counter

This block measures the frequency of an asynchronous digital input against a faster reference clock using two counters that share one gate. A free-running divider on the reference clock emits a phase tick every `TICK_DIV` cycles. A coincidence is a cycle in which a synchronized rising edge of the input falls on a tick. After a start request, the gate opens at the first coincidence. It closes at the first later coincidence that comes once a programmable minimum gate length has passed.

Both ends of the gate sit on edges of both signals, so the gate spans whole periods of the input and whole reference cycles. Neither count carries a one-count quantization error. The caller derives the frequency as the reference frequency times `cnt_sig / cnt_ref`. When the final counts are latched, the block pulses `done` for one cycle. If a counter would saturate, the measurement is abandoned and the overflow flag is raised. If no closing coincidence arrives in time, the measurement is abandoned and the timeout flag is raised.

Top module: `coinc_freq_meter`

## Requirements
- R1: `sig_in` passes through two reference-clock flops. Only a rising edge of that synchronized signal counts as an input edge.
- R2: A phase tick occurs in every `TICK_DIV`-th reference cycle of a free-running divider. A coincidence is a cycle in which an input edge and a tick occur together.
- R3: `start` is accepted only while idle. Acceptance clears both counts and both flags on the next edge. A `start` during a measurement has no effect on its result.
- R4: After a start is accepted, the gate opens at the first coincidence.
- R5: The gate closes at the first later coincidence where the cycle count from the opening coincidence to this one is at least `min_gate_cyc`. `cnt_ref` is that cycle count. `cnt_sig` is the number of input edges after the opening coincidence, up to and including the closing one. For a periodic input of period P cycles, with L = lcm(P, `TICK_DIV`), this gives `cnt_ref` = L·ceil(max(`min_gate_cyc`,1)/L) and `cnt_sig` = `cnt_ref`/P.
- R6: `done` is high for exactly one cycle, on the same edge that loads the counts. The counts then hold until the next accepted start.
- R7: An abort occurs if either counter would exceed 2^`CNT_W`-1 during the gate. On abort, `ovf_flag` is set, no `done` is given, the counts stay zero and the block returns to idle.
- R8: The timeout limit is `max_gate_cyc` reference cycles after a start is accepted. If no closing coincidence has occurred by then, the block returns to idle on the next edge with `tmo_flag` set, no `done` and the counts at zero. A closing coincidence in the same cycle takes precedence over the timeout.
- R9: During reset, the counts are zero and `done`, `ovf_flag` and `tmo_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Measured signal, asynchronous |
| start | input | 1 | Measurement request |
| min_gate_cyc | input | CNT_W | Minimum gate length in reference cycles |
| max_gate_cyc | input | TMO_W | Timeout limit in reference cycles after start |
| cnt_sig | output | CNT_W | Final count of input edges in the gate |
| cnt_ref | output | CNT_W | Final count of reference cycles in the gate |
| done | output | 1 | One-cycle pulse when counts are latched |
| ovf_flag | output | 1 | Last measurement aborted on counter saturation |
| tmo_flag | output | 1 | Last measurement aborted on timeout |

## Verification
The bench builds the block with `CNT_W` = 8, `TMO_W` = 12 and `TICK_DIV` = 4. The narrow counters bring saturation within a few hundred cycles, and the narrow timeout field keeps the timeout window short. Input periods are odd, so their lcm with the tick period is exact and a coincidence is always reachable. The expected counts then follow from R5 with no knowledge of the divider phase, and minimum lengths just below, at and above a multiple of that lcm probe the gate-closing rule.

// File: rtl/cfm_pkg.sv
`timescale 1ns/1ps
package cfm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_GATE = 2'd2
  } cfm_state_e;

  // Gate length accepted once it reaches the programmed minimum.
  function automatic logic gate_long_enough(input logic [63:0] span,
                                            input logic [63:0] min_len);
    return span >= min_len;
  endfunction

  // Elapsed waiting time has reached the limit.
  function automatic logic wait_expired(input logic [63:0] elapsed,
                                        input logic [63:0] limit);
    return elapsed >= limit;
  endfunction

endpackage

// File: rtl/cfm_sync_edge.sv
`timescale 1ns/1ps
module cfm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/cfm_tick_gen.sv
`timescale 1ns/1ps
module cfm_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] ph;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          ph <= '0;
        else if (ph == LAST) ph <= '0;
        else                 ph <= ph + 1'b1;
      end
      assign tick = (ph == LAST);
    end
  endgenerate
endmodule

// File: rtl/cfm_gate_counter.sv
`timescale 1ns/1ps
module cfm_gate_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  assign at_max = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (inc && !at_max) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfm_gate_fsm.sv
`timescale 1ns/1ps
module cfm_gate_fsm
  import cfm_pkg::*;
#(
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             coinc,
  input  logic             close_ok,
  input  logic             ovf_evt,
  input  logic [TMO_W-1:0] max_gate_cyc,
  output cfm_state_e       state,
  output logic             start_acc,
  output logic             open_evt,
  output logic             close_evt,
  output logic             tmo_evt
);
  logic [TMO_W-1:0] wait_cnt;
  logic             busy;
  logic             tmo_hit;
  cfm_state_e       nxt;

  assign busy      = (state != ST_IDLE);
  assign tmo_hit   = busy && wait_expired(64'(wait_cnt), 64'(max_gate_cyc));
  assign start_acc = (state == ST_IDLE) && start;
  assign open_evt  = (state == ST_ARM) && coinc && !tmo_hit;
  assign close_evt = (state == ST_GATE) && close_ok && !ovf_evt;
  assign tmo_evt   = tmo_hit && !close_evt && !((state == ST_GATE) && ovf_evt);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_ARM;
      ST_ARM: begin
        if (tmo_hit)    nxt = ST_IDLE;
        else if (coinc) nxt = ST_GATE;
      end
      ST_GATE: if (ovf_evt || close_evt || tmo_hit) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wait_cnt <= '0;
    end else begin
      state <= nxt;
      if (start_acc)                wait_cnt <= '0;
      else if (busy && !(&wait_cnt)) wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/coinc_freq_meter.sv
`timescale 1ns/1ps
module coinc_freq_meter
  import cfm_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TMO_W    = 32,
  parameter int TICK_DIV = 16,
  parameter int SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic             start,
  input  logic [CNT_W-1:0] min_gate_cyc,
  input  logic [TMO_W-1:0] max_gate_cyc,
  output logic [CNT_W-1:0] cnt_sig,
  output logic [CNT_W-1:0] cnt_ref,
  output logic             done,
  output logic             ovf_flag,
  output logic             tmo_flag
);
  // Named internal events (also observed by the checker)
  logic             rise, tick, coinc;
  logic             in_arm, in_gate;
  logic             start_acc, open_evt, close_evt, tmo_evt, ovf_evt, close_ok;
  logic [CNT_W-1:0] ref_run, sig_run;
  logic             ref_full, sig_full;
  logic [CNT_W:0]   ref_span;
  cfm_state_e       state;

  cfm_sync_edge #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise(rise));

  cfm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  assign coinc   = rise & tick;
  assign in_arm  = (state == ST_ARM);
  assign in_gate = (state == ST_GATE);

  cfm_gate_counter #(.W(CNT_W)) u_ref_ctr (
    .clk(clk), .rst_n(rst_n), .clr(open_evt), .inc(in_gate),
    .cnt(ref_run), .at_max(ref_full));

  cfm_gate_counter #(.W(CNT_W)) u_sig_ctr (
    .clk(clk), .rst_n(rst_n), .clr(open_evt), .inc(in_gate & rise),
    .cnt(sig_run), .at_max(sig_full));

  assign ref_span = {1'b0, ref_run} + 1'b1;
  assign ovf_evt  = in_gate & (ref_full | (rise & sig_full));
  assign close_ok = coinc & gate_long_enough(64'(ref_span), 64'(min_gate_cyc));

  cfm_gate_fsm #(.TMO_W(TMO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .coinc(coinc),
    .close_ok(close_ok), .ovf_evt(ovf_evt), .max_gate_cyc(max_gate_cyc),
    .state(state), .start_acc(start_acc), .open_evt(open_evt),
    .close_evt(close_evt), .tmo_evt(tmo_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_sig  <= '0;
      cnt_ref  <= '0;
      done     <= 1'b0;
      ovf_flag <= 1'b0;
      tmo_flag <= 1'b0;
    end else if (start_acc) begin
      cnt_sig  <= '0;
      cnt_ref  <= '0;
      done     <= 1'b0;
      ovf_flag <= 1'b0;
      tmo_flag <= 1'b0;
    end else begin
      done <= close_evt;
      if (close_evt) begin
        cnt_ref <= ref_span[CNT_W-1:0];
        cnt_sig <= sig_run + 1'b1;
      end
      if (ovf_evt) ovf_flag <= 1'b1;
      if (tmo_evt) tmo_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/cfm_checker.sv
`timescale 1ns/1ps
module cfm_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             coinc,
  input logic             in_arm,
  input logic             in_gate,
  input logic             start_acc,
  input logic             close_evt,
  input logic             ovf_evt,
  input logic             tmo_evt,
  input logic             done,
  input logic             ovf_flag,
  input logic             tmo_flag,
  input logic [CNT_W-1:0] cnt_ref,
  input logic [CNT_W-1:0] cnt_sig,
  input logic [CNT_W-1:0] min_gate_cyc
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!close_evt && !start_acc) |=> ($stable(cnt_ref) && $stable(cnt_sig)));
  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (in_arm && cnt_ref == '0 && cnt_sig == '0 && !ovf_flag && !tmo_flag));
  // R4
  open_on_coinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_arm && !coinc) |=> !in_gate);
  // R5
  close_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_ref >= min_gate_cyc && $past(coinc)));
  // R7
  ovf_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (ovf_flag && !done && !in_gate));
  // R8
  tmo_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (tmo_flag && !done && !in_arm && !in_gate));
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_flag && tmo_flag));
endmodule

bind coinc_freq_meter cfm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .coinc(coinc), .in_arm(in_arm), .in_gate(in_gate),
  .start_acc(start_acc), .close_evt(close_evt), .ovf_evt(ovf_evt),
  .tmo_evt(tmo_evt), .done(done), .ovf_flag(ovf_flag), .tmo_flag(tmo_flag),
  .cnt_ref(cnt_ref), .cnt_sig(cnt_sig), .min_gate_cyc(min_gate_cyc));

// File: tb/coinc_freq_meter_tb.sv
`timescale 1ns/1ps
module coinc_freq_meter_tb;
  localparam int CW  = 8;
  localparam int TW  = 12;
  localparam int DIV = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sig_in = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] min_gate = '0;
  logic [TW-1:0] max_gate = '0;
  logic [CW-1:0] cnt_sig, cnt_ref;
  logic          done, ovf_flag, tmo_flag;

  int checks = 0;
  int fails  = 0;

  // period, minimum gate, expected cnt_sig, expected cnt_ref (from R5 formula)
  localparam int NV = 6;
  localparam int VEC [NV][4] = '{
    '{3,   1,  4,  12},
    '{5,  30,  8,  40},
    '{7,  28,  4,  28},
    '{9,  37,  8,  72},
    '{13,  0,  4,  52},
    '{3, 100, 36, 108}
  };

  coinc_freq_meter #(.CNT_W(CW), .TMO_W(TW), .TICK_DIV(DIV), .SYNC_STG(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
    .min_gate_cyc(min_gate), .max_gate_cyc(max_gate),
    .cnt_sig(cnt_sig), .cnt_ref(cnt_ref), .done(done),
    .ovf_flag(ovf_flag), .tmo_flag(tmo_flag));

  always #2.5 clk = ~clk;

  // Periodic input: one-cycle high pulse every gen_per cycles
  int gen_per = 3;
  int gen_ph  = 0;
  bit gen_en  = 1'b0;
  always @(negedge clk) begin
    if (gen_en) begin
      sig_in = (gen_ph == 0);
      gen_ph = (gen_ph >= gen_per - 1) ? 0 : gen_ph + 1;
    end else begin
      sig_in = 1'b0;
      gen_ph = 0;
    end
  end

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Wait at negedges until done or an abort flag; report whether done was seen
  task automatic wait_end(input int lim, output bit saw_done);
    saw_done = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done) begin saw_done = 1'b1; return; end
      if (ovf_flag || tmo_flag) return;
    end
  endtask

  initial begin
    repeat (200000 / 2) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    // R9 reset state
    repeat (4) @(negedge clk);
    check("R9", "cnt_ref in reset", int'(cnt_ref), 0);
    check("R9", "cnt_sig in reset", int'(cnt_sig), 0);
    check("R9", "flags in reset", int'({done, ovf_flag, tmo_flag}), 0);
    rst_n = 1'b1;
    max_gate = TW'(2000);

    // Vector walk: R1 R2 R4 R5 (counts), R3 (clear), R6 (pulse and hold)
    for (int v = 0; v < NV; v++) begin
      gen_per  = VEC[v][0];
      min_gate = CW'(VEC[v][1]);
      gen_en   = 1'b1;
      repeat (20) @(negedge clk);
      pulse_start();
      check("R3", "cnt_ref cleared after start", int'(cnt_ref), 0);
      wait_end(1000, got);
      check("R5", "done reached", int'(got), 1);
      check("R5", "cnt_ref", int'(cnt_ref), VEC[v][3]);
      check("R1", "cnt_sig", int'(cnt_sig), VEC[v][2]);
      check("R2", "no abort flags", int'({ovf_flag, tmo_flag}), 0);
      @(negedge clk);
      check("R6", "done one cycle", int'(done), 0);
      repeat (10) @(negedge clk);
      check("R6", "cnt_ref held", int'(cnt_ref), VEC[v][3]);
      check("R6", "cnt_sig held", int'(cnt_sig), VEC[v][2]);
    end

    // R3 start during a measurement is ignored
    gen_per = 5; min_gate = CW'(30);
    repeat (20) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_end(1000, got);
    check("R3", "done with extra start", int'(got), 1);
    check("R3", "cnt_ref with extra start", int'(cnt_ref), 40);
    check("R3", "cnt_sig with extra start", int'(cnt_sig), 8);

    // R8 timeout with no input edges, exact cycle
    gen_en = 1'b0; max_gate = TW'(50);
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (50) @(negedge clk);
    check("R8", "tmo_flag before limit", int'(tmo_flag), 0);
    @(negedge clk);
    check("R8", "tmo_flag at limit", int'(tmo_flag), 1);
    check("R8", "no done on timeout", int'(done), 0);
    check("R8", "cnt_ref on timeout", int'(cnt_ref), 0);

    // R7 counter saturation: coincidences at 252 and 264, minimum 255
    gen_en = 1'b1; gen_per = 3; min_gate = CW'(255); max_gate = TW'(2000);
    repeat (20) @(negedge clk);
    pulse_start();
    check("R3", "tmo_flag cleared by start", int'(tmo_flag), 0);
    wait_end(1000, got);
    check("R7", "no done on overflow", int'(got), 0);
    check("R7", "ovf_flag", int'(ovf_flag), 1);
    check("R7", "cnt_ref on overflow", int'(cnt_ref), 0);
    check("R7", "tmo_flag on overflow", int'(tmo_flag), 0);

    // R3 recovery after abort
    min_gate = CW'(1);
    pulse_start();
    check("R3", "ovf_flag cleared by start", int'(ovf_flag), 0);
    wait_end(1000, got);
    check("R3", "recovery cnt_ref", int'(cnt_ref), 12);
    check("R3", "recovery cnt_sig", int'(cnt_sig), 4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule